// File: doc/BRIEF.md
# Split-Access 64-bit Register Bridge

This block is a slave on a 32-bit register bus. Behind it sits a small bank of 64-bit registers: a master configuration register, a parameterised number of general scratch registers, and one free-running 64-bit event counter. Each 64-bit register is seen on the bus as two consecutive 32-bit words, and the bridge keeps every 64-bit value coherent even though the bus moves only half of it per access.

A write to the word at the lower address is parked in a staging latch. The write to the higher-address word commits both halves in a single cycle. Reading the first word of the live counter freezes the other half, so a second read returns a matching half even if the counter has moved. Two configuration inputs choose which word of a pair holds the upper 32 bits and whether the bytes of each bus word are reversed. Bit 31 of the configuration register is a soft reset that clears itself and returns the whole bank to its reset state.

Top module: `split_reg_bridge`

## Requirements
- R1: The register index is bus_addr_i[ADDR_W-1:3] and bit 2 selects the word (0 = lower address, 1 = higher address); bits 1:0 are ignored. Index 0 is the configuration register, indices 1..NUM_SCRATCH are scratch registers, index NUM_SCRATCH+1 is the counter (defaults: 0x00, 0x08, 0x10, 0x18).
- R2: A write to the lower-address word of the configuration or a scratch register only loads the staging latch; the register itself keeps its value.
- R3: A write to the higher-address word commits the full 64-bit value in one cycle, built from that word and the staging latch; the staged half is zero if no lower-address write occurred since the last commit, and the latch returns to zero after every commit.
- R4: With cfg_word_swap_i = 0 the lower-address word carries bits 63:32 and the higher-address word bits 31:0; with cfg_word_swap_i = 1 the lower-address word carries bits 31:0 and the higher-address word bits 63:32.
- R5: With cfg_big_endian_i = 1 the four bytes of each 32-bit word are reversed on both write data and read data; with 0 they pass unchanged.
- R6: Read data is registered at the clock edge that samples bus_rd_en_i and holds its value until the next read; a read of an unmapped index returns zero.
- R7: The counter increments by one on every clock with evt_i high and is read-only: writes to either of its words change neither the counter nor the staging latch.
- R8: Writes to unmapped indices have no effect on any register or on the staging latch.
- R9: Reading the counter's lower-address word captures its other word in a snapshot; the next read of the higher-address word returns the snapshot and invalidates it, a higher-address read with no valid snapshot returns the live value, and a repeated lower-address read refreshes the snapshot.
- R10: Configuration bits other than bit 31 are plain storage. Committing a value with bit 31 set drives soft_rst_o high for exactly one cycle, starting the cycle after the commit; at the end of that cycle every register, the staging latch, the snapshot and the read data are zero.
- R11: After rst_n is released, every register reads zero and soft_rst_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word_swap_i | input | 1 | Word order select within a pair |
| cfg_big_endian_i | input | 1 | Byte reversal select for bus words |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wr_en_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_en_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| evt_i | input | 1 | Counter increment strobe |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |

## Verification
The properties take for granted that the two configuration inputs stay fixed while a two-word access is in progress and that evt_i is a clean single-cycle-per-count strobe. They also assume the bus issues at most one read and one write per cycle with a settled address. The stimulus changes word order and endianness only between complete register accesses. It holds evt_i low whenever a read is issued, so each expected counter value follows from the pulses sent before that read.

// File: rtl/split_reg_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, region type and word helpers for the
// split-access register bridge. Assumes a 32-bit bus and 64-bit registers.
package split_reg_pkg;

    localparam int WORD_W   = 32;
    localparam int REG_W    = 2 * WORD_W;
    localparam int SRST_BIT = 31;

    // Which part of the bank an address falls into.
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CFG  = 2'd1,
        RGN_SCR  = 2'd2,
        RGN_CNT  = 2'd3
    } region_e;

    // Reverse the byte lanes of one bus word.
    function automatic logic [WORD_W-1:0] bswap(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // Select the upper (1) or lower (0) half of a 64-bit value.
    function automatic logic [WORD_W-1:0] half_of(input logic [REG_W-1:0] v,
                                                  input logic upper);
        return upper ? v[REG_W-1:WORD_W] : v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/split_bus_decode.sv
`timescale 1ns/1ps
// Module: split_bus_decode
// Purely combinational decode of one bus access: finds the region and
// scratch index, tells which word of the pair is addressed, which 64-bit
// half that word maps to under the current word order, and converts the
// write data to host byte order. Assumes word-aligned use of the address.
module split_bus_decode
    import split_reg_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_SCRATCH = 2,
    localparam int IDX_W      = ADDR_W - 3,
    localparam int SCR_IDX_W  = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [WORD_W-1:0]    wdata_i,
    input  logic                 word_swap_i,
    input  logic                 big_endian_i,
    output region_e              region_o,
    output logic [SCR_IDX_W-1:0] scr_idx_o,
    output logic                 hi_addr_o,
    output logic                 upper_o,
    output logic [WORD_W-1:0]    wdata_host_o
);

    logic [IDX_W-1:0] reg_idx;
    logic [IDX_W-1:0] scr_off;

    assign reg_idx   = addr_i[ADDR_W-1:3];
    assign hi_addr_o = addr_i[2];
    assign scr_off   = reg_idx - IDX_W'(1);
    assign scr_idx_o = scr_off[SCR_IDX_W-1:0];

    // Map the register index onto a region of the bank.
    always_comb begin
        if (reg_idx == '0) begin
            region_o = RGN_CFG;
        end else if (int'(reg_idx) <= NUM_SCRATCH) begin
            region_o = RGN_SCR;
        end else if (int'(reg_idx) == NUM_SCRATCH + 1) begin
            region_o = RGN_CNT;
        end else begin
            region_o = RGN_NONE;
        end
    end

    // Lower-address word holds the upper half unless the order is swapped.
    assign upper_o = (~hi_addr_o) ^ word_swap_i;

    // Bring write data into host byte order.
    assign wdata_host_o = big_endian_i ? bswap(wdata_i) : wdata_i;

endmodule

// File: rtl/split_wstage.sv
`timescale 1ns/1ps
// Module: split_wstage
// Staging latch and commit builder. A lower-address write to a writable
// register parks its word; a higher-address write forms the 64-bit value
// from the new word and the parked word and flags a commit. The latch is
// shared by all writable registers and is zeroed after each commit.
module split_wstage
    import split_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr_i,
    input  logic              wr_en_i,
    input  logic              writable_i,
    input  logic              hi_addr_i,
    input  logic              upper_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              commit_o,
    output logic [REG_W-1:0]  commit_val_o,
    output logic [WORD_W-1:0] stage_o
);

    logic [WORD_W-1:0] stage_q;
    logic              park;

    assign park     = wr_en_i & writable_i & ~hi_addr_i;
    assign commit_o = wr_en_i & writable_i & hi_addr_i;

    // Place the new word into its half and the parked word into the other.
    always_comb begin
        if (upper_i) begin
            commit_val_o = {wdata_i, stage_q};
        end else begin
            commit_val_o = {stage_q, wdata_i};
        end
    end

    // Hold the lower-address word until its partner arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr_i) begin
            stage_q <= '0;
        end else if (park) begin
            stage_q <= wdata_i;
        end else if (commit_o) begin
            stage_q <= '0;
        end
    end

    assign stage_o = stage_q;

endmodule

// File: rtl/split_cnt_snap.sv
`timescale 1ns/1ps
// Module: split_cnt_snap
// Free-running 64-bit event counter with a one-entry read snapshot.
// Reading the first word captures the other half of the same count;
// reading the second word consumes the capture. Assumes the caller
// signals the first/second read in the cycle the bus samples it.
module split_cnt_snap
    import split_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr_i,
    input  logic              evt_i,
    input  logic              rd_first_i,
    input  logic              rd_second_i,
    input  logic              upper_first_i,
    output logic [REG_W-1:0]  cnt_o,
    output logic [WORD_W-1:0] snap_o,
    output logic              snap_vld_o
);

    logic [REG_W-1:0]  cnt_q;
    logic [WORD_W-1:0] snap_q;
    logic              snap_vld_q;

    // Count one per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr_i) begin
            cnt_q <= '0;
        end else if (evt_i) begin
            cnt_q <= cnt_q + REG_W'(1);
        end
    end

    // Capture the partner half on a first-word read, drop it on the second.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr_i) begin
            snap_q     <= '0;
            snap_vld_q <= 1'b0;
        end else if (rd_first_i) begin
            snap_q     <= half_of(cnt_q, ~upper_first_i);
            snap_vld_q <= 1'b1;
        end else if (rd_second_i) begin
            snap_vld_q <= 1'b0;
        end
    end

    assign cnt_o      = cnt_q;
    assign snap_o     = snap_q;
    assign snap_vld_o = snap_vld_q;

endmodule

// File: rtl/split_reg_bridge.sv
`timescale 1ns/1ps
// Module: split_reg_bridge (top)
// 32-bit bus slave exposing a bank of 64-bit registers as word pairs:
// configuration register with self-clearing soft reset, scratch registers
// and a read-only event counter. Writes commit on the higher-address word;
// counter reads are made coherent by a snapshot. Assumes configuration
// inputs do not change in the middle of a two-word access.
module split_reg_bridge
    import split_reg_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_SCRATCH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_word_swap_i,
    input  logic              cfg_big_endian_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_en_i,
    input  logic [31:0]       bus_wdata_i,
    input  logic              bus_rd_en_i,
    output logic [31:0]       bus_rdata_o,
    input  logic              evt_i,
    output logic              soft_rst_o
);

    localparam int SCR_IDX_W = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1;

    region_e              region;
    logic [SCR_IDX_W-1:0] scr_idx;
    logic                 hi_addr;
    logic                 upper;
    logic [WORD_W-1:0]    wdata_host;

    logic                 writable;
    logic                 commit;
    logic [REG_W-1:0]     commit_val;
    logic [WORD_W-1:0]    stage_val;

    logic [REG_W-1:0]     cnt_val;
    logic [WORD_W-1:0]    snap_val;
    logic                 snap_vld;
    logic                 cnt_rd_first;
    logic                 cnt_rd_second;

    logic [REG_W-1:0]     cfg_q;
    logic [REG_W-1:0]     scr_q [NUM_SCRATCH];
    logic                 soft_clr;
    logic                 wr_unmapped;
    logic [WORD_W-1:0]    rd_word;
    logic [WORD_W-1:0]    rdata_q;

    split_bus_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_SCRATCH (NUM_SCRATCH)
    ) u_decode (
        .addr_i       (bus_addr_i),
        .wdata_i      (bus_wdata_i),
        .word_swap_i  (cfg_word_swap_i),
        .big_endian_i (cfg_big_endian_i),
        .region_o     (region),
        .scr_idx_o    (scr_idx),
        .hi_addr_o    (hi_addr),
        .upper_o      (upper),
        .wdata_host_o (wdata_host)
    );

    assign writable    = (region == RGN_CFG) || (region == RGN_SCR);
    assign wr_unmapped = bus_wr_en_i && (region == RGN_NONE);
    assign soft_clr    = cfg_q[SRST_BIT];

    split_wstage u_wstage (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_clr_i   (soft_clr),
        .wr_en_i      (bus_wr_en_i),
        .writable_i   (writable),
        .hi_addr_i    (hi_addr),
        .upper_i      (upper),
        .wdata_i      (wdata_host),
        .commit_o     (commit),
        .commit_val_o (commit_val),
        .stage_o      (stage_val)
    );

    assign cnt_rd_first  = bus_rd_en_i && (region == RGN_CNT) && !hi_addr;
    assign cnt_rd_second = bus_rd_en_i && (region == RGN_CNT) && hi_addr;

    split_cnt_snap u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_clr_i    (soft_clr),
        .evt_i         (evt_i),
        .rd_first_i    (cnt_rd_first),
        .rd_second_i   (cnt_rd_second),
        .upper_first_i (upper),
        .cnt_o         (cnt_val),
        .snap_o        (snap_val),
        .snap_vld_o    (snap_vld)
    );

    // Configuration register: takes committed values; bit 31 self-clears
    // through the soft clear one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            cfg_q <= '0;
        end else if (commit && (region == RGN_CFG)) begin
            cfg_q <= commit_val;
        end
    end

    // Scratch registers, one per generate slot.
    for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr) begin
                scr_q[g] <= '0;
            end else if (commit && (region == RGN_SCR) &&
                         (scr_idx == SCR_IDX_W'(g))) begin
                scr_q[g] <= commit_val;
            end
        end
    end

    // Select the host-order word the read addresses.
    always_comb begin
        rd_word = '0;
        unique case (region)
            RGN_CFG: rd_word = half_of(cfg_q, upper);
            RGN_SCR: rd_word = half_of(scr_q[scr_idx], upper);
            RGN_CNT: rd_word = (hi_addr && snap_vld) ? snap_val
                                                     : half_of(cnt_val, upper);
            default: rd_word = '0;
        endcase
    end

    // Register read data in bus byte order; hold between reads.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            rdata_q <= '0;
        end else if (bus_rd_en_i) begin
            rdata_q <= cfg_big_endian_i ? bswap(rd_word) : rd_word;
        end
    end

    assign bus_rdata_o = rdata_q;
    assign soft_rst_o  = soft_clr;

endmodule

// File: rtl/split_reg_bridge_chk.sv
`timescale 1ns/1ps
// Module: split_reg_bridge_chk
// Property checker for split_reg_bridge, attached by bind. Watches the
// soft-reset pulse, counter progress, staging latch and read data hold.
module split_reg_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        evt,
    input logic [63:0] cnt,
    input logic [31:0] stage,
    input logic        commit,
    input logic        wr_unmapped,
    input logic        rd_en,
    input logic [31:0] rdata
);

    // R10: the soft reset lasts one cycle.
    assert_srst_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    // R10: the soft reset leaves the counter at zero.
    assert_srst_clears_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cnt == 64'd0));

    // R7: the counter moves only by the strobe, whatever the bus does.
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> (cnt == $past(cnt) + 64'($past(evt))));

    // R8: unmapped writes leave the staging latch alone.
    assert_unmapped_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_unmapped && !soft_rst) |=> $stable(stage));

    // R3: the staging latch is empty after a commit.
    assert_stage_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !soft_rst) |=> (stage == 32'd0));

    // R6: read data holds without a read.
    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !soft_rst) |=> $stable(rdata));

endmodule

bind split_reg_bridge split_reg_bridge_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst_o),
    .evt         (evt_i),
    .cnt         (cnt_val),
    .stage       (stage_val),
    .commit      (commit),
    .wr_unmapped (wr_unmapped),
    .rd_en       (bus_rd_en_i),
    .rdata       (bus_rdata_o)
);

// File: tb/tb_split_reg_bridge.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected words, a monitor pops and
// compares them the cycle the registered read data appears.
module tb_split_reg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_word_swap = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;
    logic        evt = 1'b0;
    logic        soft_rst;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        pend = 1'b0;
    logic [63:0] exp_cnt = '0;

    always #5 clk = ~clk;

    split_reg_bridge #(.ADDR_W(8), .NUM_SCRATCH(2)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_word_swap_i  (cfg_word_swap),
        .cfg_big_endian_i (cfg_big_endian),
        .bus_addr_i       (bus_addr),
        .bus_wr_en_i      (bus_wr_en),
        .bus_wdata_i      (bus_wdata),
        .bus_rd_en_i      (bus_rd_en),
        .bus_rdata_o      (bus_rdata),
        .evt_i            (evt),
        .soft_rst_o       (soft_rst)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Monitor: a read sampled at the last edge has its data now.
    always @(posedge clk) pend <= bus_rd_en;
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", 32'hdead_beef, 32'h0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp,
                      input string tag);
        bus_addr  = a;
        bus_rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        evt = 1'b1;
        repeat (n) @(negedge clk);
        evt = 1'b0;
        exp_cnt += 64'(n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: everything starts at zero.
        check("R11 soft_rst idle", {31'd0, soft_rst}, 32'd0);
        rd(8'h00, 32'h0, "R11 cfg word0");
        rd(8'h04, 32'h0, "R11 cfg word1");
        rd(8'h08, 32'h0, "R11 scratch0");
        rd(8'h18, 32'h0, "R11 counter");

        // R10: configuration bits other than 31 store normally.
        wr(8'h00, 32'h1234_5678);
        wr(8'h04, 32'h0000_00ff);
        rd(8'h00, 32'h1234_5678, "R10 cfg upper stored");
        rd(8'h04, 32'h0000_00ff, "R10 cfg lower stored");

        // R2: lower-address write is only staged.
        wr(8'h08, 32'haaaa_0001);
        rd(8'h08, 32'h0, "R2 staged word not visible");
        rd(8'h0C, 32'h0, "R2 register unchanged");
        // R3: higher-address write commits both halves.
        wr(8'h0C, 32'hbbbb_0002);
        rd(8'h08, 32'haaaa_0001, "R3 commit upper");
        rd(8'h0C, 32'hbbbb_0002, "R3 commit lower");
        rd(8'h09, 32'haaaa_0001, "R1 low address bits ignored");
        // R3: higher-only write commits a zero staged half.
        wr(8'h0C, 32'hcccc_0003);
        rd(8'h08, 32'h0, "R3 unstaged half zero");
        rd(8'h0C, 32'hcccc_0003, "R3 single write lower");

        // R4: swapped word order.
        cfg_word_swap = 1'b1;
        rd(8'h08, 32'hcccc_0003, "R4 swap word0 is low half");
        rd(8'h0C, 32'h0, "R4 swap word1 is high half");
        wr(8'h08, 32'hdddd_0004);
        wr(8'h0C, 32'heeee_0005);
        cfg_word_swap = 1'b0;
        rd(8'h08, 32'heeee_0005, "R4 swapped write high half");
        rd(8'h0C, 32'hdddd_0004, "R4 swapped write low half");

        // R5: big-endian bus.
        cfg_big_endian = 1'b1;
        wr(8'h10, 32'h1122_3344);
        wr(8'h14, 32'h5566_7788);
        rd(8'h10, 32'h1122_3344, "R5 big-endian round trip");
        cfg_big_endian = 1'b0;
        rd(8'h10, 32'h4433_2211, "R5 stored bytes reversed upper");
        rd(8'h14, 32'h8877_6655, "R5 stored bytes reversed lower");

        // R9: counter snapshot.
        pulse(5);
        rd(8'h18, exp_cnt[63:32], "R9 counter first word");
        pulse(3);
        rd(8'h1C, 32'd5, "R9 snapshot returned");
        rd(8'h1C, exp_cnt[31:0], "R9 live after snapshot used");
        rd(8'h18, 32'h0, "R9 first read");
        pulse(2);
        rd(8'h18, 32'h0, "R9 refresh read");
        pulse(1);
        rd(8'h1C, 32'd10, "R9 refreshed snapshot");
        rd(8'h1C, exp_cnt[31:0], "R9 live value");

        // R7, R8: counter and unmapped writes ignored, stage intact.
        wr(8'h10, 32'h5151_0006);
        wr(8'h18, 32'hffff_ffff);
        wr(8'h1C, 32'hffff_ffff);
        wr(8'h40, 32'h7777_7777);
        wr(8'h14, 32'h7171_0007);
        rd(8'h10, 32'h5151_0006, "R8 staged word survives ignored writes");
        rd(8'h14, 32'h7171_0007, "R8 commit after ignored writes");
        rd(8'h1C, exp_cnt[31:0], "R7 counter writes ignored");
        rd(8'h18, exp_cnt[63:32], "R7 counter upper untouched");
        rd(8'h1C, exp_cnt[31:0], "R7 counter consume snapshot");

        // R6: unmapped reads are zero, data holds without reads.
        rd(8'h14, 32'h7171_0007, "R6 read before hold");
        repeat (3) @(negedge clk);
        check("R6 read data held", bus_rdata, 32'h7171_0007);
        rd(8'h40, 32'h0, "R6 unmapped read zero");
        rd(8'h20, 32'h0, "R6 index past counter zero");

        // R10: soft reset.
        wr(8'h04, 32'h8000_0000);
        check("R10 soft reset pulse high", {31'd0, soft_rst}, 32'd1);
        @(negedge clk);
        check("R10 soft reset pulse ends", {31'd0, soft_rst}, 32'd0);
        check("R10 read data cleared", bus_rdata, 32'h0);
        exp_cnt = '0;
        rd(8'h08, 32'h0, "R10 scratch0 cleared");
        rd(8'h14, 32'h0, "R10 scratch1 cleared");
        rd(8'h1C, 32'h0, "R10 counter cleared");
        rd(8'h00, 32'h0, "R10 cfg cleared");
        rd(8'h04, 32'h0, "R10 cfg bit31 cleared");
        @(negedge clk);

        if (exp_q.size() != 0) check("scoreboard leftover", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule